// File: doc/BRIEF.md
# Orbit-Locked Trigger Burst Generator

This block produces level-1 accept (L1A) pulses in short, fixed bursts so that downstream readout can be stressed with closely spaced triggers. It counts orbit markers and, at regular orbit intervals, plays one of sixteen built-in spacing patterns out on the L1A line. Each pattern bit occupies one bunch-crossing clock (25 ns in the target system), and a 1 bit is a trigger in that clock. Pattern 1, for example, puts two trigger leading edges 50 ns apart.

Two modes exist. In the plain mode every burst opportunity plays the selected pattern. In the mixed mode opportunities come four times as often, and the block interleaves lone triggers with the selected pattern: three lone triggers, then one full pattern. A burst-active flag marks every clock of a pattern being played, which lets a capture system align its window. The pattern select is read only on the orbit marker that opens a burst, so it can be changed at any time without corrupting a burst in flight.

Top module: `l1a_burst_gen`

## Requirements
- R1: During reset and in the first cycle after reset, `l1a_o` and `burst_o` are low. The orbit counter and the mixed-mode opportunity counter start at zero, so the first orbit marker after reset is a burst opportunity.
- R2: For a marker sampled in cycle k, the first pattern bit appears in cycle k+1+START_OFFSET. Bits are played leftmost first, one per clock.
- R3: `burst_o` is high for exactly as many consecutive cycles as the played pattern has bits (at most 15). `l1a_o` is high only while `burst_o` is high.
- R4: The select codes map to these patterns: 0 "1", 1 "101", 2 "10101", 3 "1001", 4 "1001001", 5 "10001", 6 "100010001", 8 "11", 9 "111", 10 "100000010000001". Every pattern starts and ends with a 1.
- R5: Codes 7 and 11 to 15 play nothing: `l1a_o` and `burst_o` stay low for that opportunity.
- R6: An orbit-marker counter advances on each marker and wraps to 0 after it reaches the current mode's period minus one; a value above that limit also wraps to 0. A marker that arrives while the counter is 0 is an opportunity. In plain mode (`alt_mode_i`=0) the period is BASE_ORBITS (256), and the other markers produce no output.
- R7: In mixed mode (`alt_mode_i`=1) the period is ALT_ORBITS (64). Opportunities are counted from 0 and the count wraps after ALT_RATIO-1 (3). Counts 0 to 2 play a single trigger ("1"), and count 3 plays the selected pattern. The count is held at 0 while in plain mode.
- R8: `pat_sel_i` is sampled only on the opportunity marker. Changing it during a burst, or between opportunities, does not alter the burst being played.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| orbit_i | input | 1 | Orbit marker, high for one clock per orbit |
| pat_sel_i | input | 4 | Pattern select code |
| alt_mode_i | input | 1 | 0: pattern every BASE_ORBITS; 1: mixed singles and pattern every ALT_ORBITS |
| l1a_o | output | 1 | Trigger pulse, one clock per 1 bit |
| burst_o | output | 1 | High for every clock of a pattern being played |

## Verification
The bound checker watches, on every clock, the properties that hold for any pattern: a trigger never appears outside the active flag, a burst opens and closes on a trigger, it never runs past fifteen clocks, it rises exactly START_OFFSET+1 clocks after a marker, and the outputs are quiet after reset. What only the bench's scenarios can show is the content of each of the sixteen table entries, the 256- and 64-orbit spacing, the three-singles-then-pattern rotation of the mixed mode, and the fact that a select value scrambled on every non-opportunity cycle never leaks into a burst. The bench's behavioural model predicts both outputs for every clock across a plain-mode sweep of all codes and a mixed-mode run that follows a mode switch in mid-count.

// File: rtl/l1ab_pkg.sv
// Package: shared types and the pattern table for the trigger burst generator.
// Patterns are stored left-justified in a PAT_W-bit vector, with their
// length beside them, so the sequencer can always shift out of the top bit.
package l1ab_pkg;

    localparam int PAT_W = 15;                 // longest pattern, in clocks
    localparam int LEN_W = $clog2(PAT_W + 1);  // width of a length field
    localparam int SEL_W = 4;                  // width of the select code

    // One entry of the pattern table.
    typedef struct packed {
        logic [LEN_W-1:0] len;   // number of bits to play, 0 = nothing
        logic [PAT_W-1:0] bits;  // first bit to play sits in bit PAT_W-1
    } pat_t;

    // Builds a left-justified entry from a right-justified bit string.
    function automatic pat_t pat_make(input int n, input logic [PAT_W-1:0] v);
        pat_t p;
        p.len  = LEN_W'(n);
        p.bits = (n == 0) ? '0 : (v << (PAT_W - n));
        return p;
    endfunction

    // The pattern table; unlisted codes play nothing.
    function automatic pat_t pat_lookup(input logic [SEL_W-1:0] sel);
        pat_t p;
        case (sel)
            4'd0:    p = pat_make(1,  15'b1);
            4'd1:    p = pat_make(3,  15'b101);
            4'd2:    p = pat_make(5,  15'b10101);
            4'd3:    p = pat_make(4,  15'b1001);
            4'd4:    p = pat_make(7,  15'b1001001);
            4'd5:    p = pat_make(5,  15'b10001);
            4'd6:    p = pat_make(9,  15'b100010001);
            4'd8:    p = pat_make(2,  15'b11);
            4'd9:    p = pat_make(3,  15'b111);
            4'd10:   p = pat_make(15, 15'b100000010000001);
            default: p = pat_make(0,  15'b0);
        endcase
        return p;
    endfunction

    // The lone trigger used by the mixed mode.
    function automatic pat_t pat_single();
        return pat_make(1, 15'b1);
    endfunction

endpackage

// File: rtl/l1ab_orbit_sched.sv
// Orbit scheduler: counts orbit markers and flags the markers that open a
// burst opportunity. In mixed mode it also rotates an opportunity counter
// that decides between a lone trigger and the selected pattern.
// Assumes: orbit_i is a single-cycle pulse; BASE_ORBITS >= ALT_ORBITS >= 2.
module l1ab_orbit_sched #(
    parameter int BASE_ORBITS = 256,
    parameter int ALT_ORBITS  = 64,
    parameter int ALT_RATIO   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic orbit_i,
    input  logic alt_mode_i,
    output logic fire_o,   // this marker opens a burst opportunity
    output logic full_o    // play the selected pattern (else a lone trigger)
);
    localparam int CNT_W = (BASE_ORBITS < 2) ? 1 : $clog2(BASE_ORBITS);
    localparam int OPP_W = (ALT_RATIO < 2) ? 1 : $clog2(ALT_RATIO);
    localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE_ORBITS - 1);
    localparam logic [CNT_W-1:0] ALT_LAST  = CNT_W'(ALT_ORBITS - 1);
    localparam logic [OPP_W-1:0] OPP_LAST  = OPP_W'(ALT_RATIO - 1);

    logic [CNT_W-1:0] orb_cnt_q;
    logic [OPP_W-1:0] opp_cnt_q;
    logic [CNT_W-1:0] period_last;

    // Select the wrap point of the current mode.
    always_comb begin
        period_last = alt_mode_i ? ALT_LAST : BASE_LAST;
    end

    // Decode an opportunity and the pattern choice for it.
    always_comb begin
        fire_o = orbit_i && (orb_cnt_q == '0);
        full_o = !alt_mode_i || (opp_cnt_q == OPP_LAST);
    end

    // Advance the orbit counter on every marker, wrapping at the mode's period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orb_cnt_q <= '0;
        end else if (orbit_i) begin
            orb_cnt_q <= (orb_cnt_q >= period_last) ? '0 : orb_cnt_q + 1'b1;
        end
    end

    // Rotate the mixed-mode opportunity counter; hold it at zero in plain mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !alt_mode_i) begin
            opp_cnt_q <= '0;
        end else if (fire_o) begin
            opp_cnt_q <= (opp_cnt_q == OPP_LAST) ? '0 : opp_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/l1ab_pat_pick.sv
// Pattern picker: turns the select code and the scheduler's choice into one
// table entry. Purely combinational; the sequencer captures the result only
// on an opportunity, which is what makes the select safe to change anytime.
module l1ab_pat_pick
    import l1ab_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic             full_i,
    output pat_t             pat_o
);
    // Choose the table entry or the lone trigger.
    always_comb begin
        pat_o = full_i ? pat_lookup(sel_i) : pat_single();
    end

endmodule

// File: rtl/l1ab_burst_seq.sv
// Burst sequencer: on a fire pulse it captures a pattern, waits START_OFFSET
// clocks and then shifts the pattern out one bit per clock, leftmost first.
// Assumes: orbits are longer than START_OFFSET + PAT_W clocks; a fire that
// arrives anyway restarts the sequencer with the new pattern.
module l1ab_burst_seq
    import l1ab_pkg::*;
#(
    parameter int START_OFFSET = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  pat_t pat_i,
    output logic l1a_o,
    output logic burst_o
);
    localparam int OFS_W = (START_OFFSET < 2) ? 1 : $clog2(START_OFFSET);
    localparam logic [OFS_W-1:0] DLY_LOAD =
        OFS_W'((START_OFFSET > 0) ? START_OFFSET - 1 : 0);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } seq_st_t;

    seq_st_t          st_q;
    seq_st_t          load_st;
    logic [PAT_W-1:0] sh_q;
    logic [LEN_W-1:0] left_q;
    logic [OFS_W-1:0] dly_q;

    // Pick the state a fresh burst enters, skipping the wait when no offset.
    generate
        if (START_OFFSET == 0) begin : g_no_wait
            always_comb load_st = ST_SEND;
        end else begin : g_wait
            always_comb load_st = ST_WAIT;
        end
    endgenerate

    // Load, delay and shift the pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            left_q <= '0;
            dly_q  <= '0;
        end else if (fire_i) begin
            sh_q   <= pat_i.bits;
            left_q <= pat_i.len;
            dly_q  <= DLY_LOAD;
            st_q   <= (pat_i.len == '0) ? ST_IDLE : load_st;
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (dly_q == '0) st_q <= ST_SEND;
                    else             dly_q <= dly_q - 1'b1;
                end
                ST_SEND: begin
                    sh_q   <= sh_q << 1;
                    left_q <= left_q - 1'b1;
                    if (left_q == LEN_W'(1)) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs straight from the state registers.
    always_comb begin
        burst_o = (st_q == ST_SEND);
        l1a_o   = (st_q == ST_SEND) && sh_q[PAT_W-1];
    end

endmodule

// File: rtl/l1a_burst_gen.sv
// Top: orbit-locked trigger burst generator. Ties the orbit scheduler, the
// pattern picker and the burst sequencer together.
// Assumes: orbit_i is one clock wide and orbits are longer than a burst.
module l1a_burst_gen
    import l1ab_pkg::*;
#(
    parameter int BASE_ORBITS  = 256,
    parameter int ALT_ORBITS   = 64,
    parameter int ALT_RATIO    = 4,
    parameter int START_OFFSET = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             orbit_i,
    input  logic [SEL_W-1:0] pat_sel_i,
    input  logic             alt_mode_i,
    output logic             l1a_o,
    output logic             burst_o
);
    logic fire;
    logic full;
    pat_t pat;

    l1ab_orbit_sched #(
        .BASE_ORBITS (BASE_ORBITS),
        .ALT_ORBITS  (ALT_ORBITS),
        .ALT_RATIO   (ALT_RATIO)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .orbit_i    (orbit_i),
        .alt_mode_i (alt_mode_i),
        .fire_o     (fire),
        .full_o     (full)
    );

    l1ab_pat_pick u_pick (
        .sel_i  (pat_sel_i),
        .full_i (full),
        .pat_o  (pat)
    );

    l1ab_burst_seq #(
        .START_OFFSET (START_OFFSET)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pat_i   (pat),
        .l1a_o   (l1a_o),
        .burst_o (burst_o)
    );

endmodule

// File: rtl/l1a_burst_gen_chk.sv
// Checker: port-level properties of the burst generator, bound to the top.
// It keeps its own run-length and marker-distance counters.
module l1a_burst_gen_chk #(
    parameter int START_OFFSET = 3
) (
    input logic clk,
    input logic rst_n,
    input logic orbit_i,
    input logic l1a_o,
    input logic burst_o
);
    localparam int MAX_RUN = l1ab_pkg::PAT_W;

    logic [15:0] run_q;    // consecutive burst cycles before this one
    logic [15:0] since_q;  // cycles since the last marker, 0 = none seen

    // Count the length of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_q <= '0;
        else if (!burst_o)          run_q <= '0;
        else if (run_q != 16'hFFFF) run_q <= run_q + 1'b1;
    end

    // Measure the distance from the last orbit marker.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     since_q <= '0;
        else if (orbit_i)                               since_q <= 16'd1;
        else if (since_q != '0 && since_q != 16'hFFFF)  since_q <= since_q + 1'b1;
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!l1a_o && !burst_o)); // R1
    AST_START_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_o) |-> (since_q == 16'(START_OFFSET + 1))); // R2
    AST_L1A_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        l1a_o |-> burst_o); // R3
    AST_BURST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> (run_q < 16'(MAX_RUN))); // R3
    AST_BURST_OPENS_ON_L1A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_o) |-> l1a_o); // R4
    AST_BURST_CLOSES_ON_L1A: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_o) |-> $past(l1a_o)); // R4

endmodule

bind l1a_burst_gen l1a_burst_gen_chk #(
    .START_OFFSET (START_OFFSET)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .orbit_i (orbit_i),
    .l1a_o   (l1a_o),
    .burst_o (burst_o)
);

// File: tb/l1a_burst_gen_bench.sv
`timescale 1ns/1ps
// Bench: drives orbit markers, a scrambled select and a mode switch, and
// compares both outputs on every clock against a behavioural model.
module l1a_burst_gen_bench;
    localparam int OFS       = 3;
    localparam int BASE      = 256;
    localparam int ALT       = 64;
    localparam int RATIO     = 4;
    localparam int ORBIT_LEN = 20;
    localparam int RST_END   = 4;
    localparam int MARK0     = 8;
    localparam int ALT_FROM  = 15 * BASE + 1;   // first marker in mixed mode
    localparam int LAST_MARK = 4354;
    localparam int TOTAL     = MARK0 + LAST_MARK * ORBIT_LEN + 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       orbit = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       alt_mode = 1'b0;
    logic       l1a, burst;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    l1a_burst_gen #(
        .BASE_ORBITS  (BASE),
        .ALT_ORBITS   (ALT),
        .ALT_RATIO    (RATIO),
        .START_OFFSET (OFS)
    ) u_l1a_burst_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .orbit_i    (orbit),
        .pat_sel_i  (sel),
        .alt_mode_i (alt_mode),
        .l1a_o      (l1a),
        .burst_o    (burst)
    );

    // Pattern strings from the requirement R4; "" for the empty codes of R5.
    function automatic string pat_str(input int s);
        case (s)
            0:  return "1";
            1:  return "101";
            2:  return "10101";
            3:  return "1001";
            4:  return "1001001";
            5:  return "10001";
            6:  return "100010001";
            8:  return "11";
            9:  return "111";
            10: return "100000010000001";
            default: return "";
        endcase
    endfunction

    // Model and stimulus, one step per falling edge.
    initial begin
        int    cnt = 0;
        int    opp = 0;
        int    j = 0;
        int    start = -1000;
        string pstr = "";
        string tag = "R1";
        for (int n = 0; n < TOTAL; n++) begin
            @(negedge clk);
            // Compare what the last rising edge produced (R2 R3 timing, R8 content).
            if (n >= 1) begin
                bit eb, el;
                string t;
                eb = (n >= start) && (n < start + pstr.len());
                el = eb && (pstr[n - start] == 8'h31);
                t  = (n <= RST_END) ? "R1" : tag;
                compared++;
                if (burst !== eb || l1a !== el) begin
                    mismatched++;
                    $display("FAIL %s cycle %0d: burst_o=%b l1a_o=%b, expected burst_o=%b l1a_o=%b",
                             t, n, burst, l1a, eb, el);
                end
            end
            // Drive the inputs for the next rising edge and advance the model.
            rst_n = (n >= RST_END);
            if (n >= MARK0 && (n - MARK0) % ORBIT_LEN == 0) begin
                int  mi;
                bit  am;
                mi = (n - MARK0) / ORBIT_LEN;
                am = (mi >= ALT_FROM);
                alt_mode = am;
                orbit = 1'b1;
                if (!am) opp = 0;
                if (cnt == 0) begin
                    bit full;
                    full = !am || (opp == RATIO - 1);
                    sel = 4'((j * 3) % 16);
                    j++;
                    pstr  = full ? pat_str(int'(sel)) : "1";
                    start = n + 1 + OFS;
                    if (!am)            tag = (pstr.len() == 0) ? "R5 R6 R8" : "R4 R6 R8";
                    else if (full)      tag = (pstr.len() == 0) ? "R5 R7 R8" : "R4 R7 R8";
                    else                tag = "R7";
                    if (am) opp = (opp == RATIO - 1) ? 0 : opp + 1;
                end
                cnt = (cnt >= (am ? ALT : BASE) - 1) ? 0 : cnt + 1;
            end else begin
                orbit = 1'b0;
                sel   = 4'((n * 7) % 16);  // scrambled away from opportunities (R8)
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(150000 * 5);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule